// File: doc/BRIEF.md
# Almost-Regular Permutation Address Generator

This block produces the read or write address sequence that scatters a turbo-code frame through its interleaver. The permutation is a regular stride walk, `P·i mod K`, with a small per-layer dither added on top. The layer is the position of `i` inside a repeating group of `Q` indices. For index `i` the block emits `(P·i + S(i mod Q)) mod K`. The stride `P`, the group length `Q` and the dither table `S` are fixed when the block is built. The frame length `K` is one of several powers of two, picked at run time, and every frame length uses the same `P` and `S`.

A one-cycle start pulse latches the size selection. From the next cycle on, the block emits one address per cycle for `i = 0 .. K-1`, with a valid flag and a flag on the final address. The modular arithmetic needs no multiplier and no divider. A running sum of `P` is wrapped by masking to the frame width, and the dither entry for the current layer is added and wrapped the same way. A build with an all-zero dither table reduces to the plain stride interleaver.

Top module: `perm_addr_gen`

## Requirements
- R1: After reset, and until the first start pulse, `valid_o` and `last_o` are low.
- R2: In the cycle after `start_i` is sampled high, `valid_o` is high and the output carries index 0, whose address is `S(0) mod K`.
- R3: While valid, consecutive cycles carry consecutive indices `i`, and `addr_o = (P·i + S(i mod Q)) mod K`. The defaults are P = 9, Q = 4 and S = {3, 13, 27, 5}, indexed by layer 0..3.
- R4: `size_sel_i` is sampled only together with a start pulse. The value 0 selects K = 32, 1 selects 64, 2 selects 128, and any value of 3 or more selects the largest size, 128. Changes of `size_sel_i` while a frame runs have no effect on that frame.
- R5: `last_o` is high exactly in the valid cycle that carries `i = K-1`. In the next cycle `valid_o` is low unless a start pulse was sampled.
- R6: A start pulse during a frame, including one in the cycle of the final address, restarts the sequence from `i = 0` in the next cycle with the newly sampled size.
- R7: Within one complete frame, each address in `0 .. K-1` appears exactly once and no address is K or above.
- R8: With an all-zero dither table, the output is `P·i mod K`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts or restarts a frame |
| size_sel_i | input | 2 | Frame-size code, sampled with `start_i` |
| addr_o | output | 7 | Permuted address for the current index |
| valid_o | output | 1 | High while an index is being emitted |
| last_o | output | 1 | High with the address for index K-1 |

## Verification
The bench walks full frames of every size, including the out-of-range size code. Each frame is checked address by address, and the frame as a whole is checked for full coverage. A wrong wrap mask would show as duplicated addresses or addresses beyond K, and a layer counter out of step with the index would apply the wrong dither entry. Three directed cases follow. The first changes the size code mid-frame, which catches a design that does not latch it. The second restarts a frame part-way through, which catches a design that ignores the pulse or keeps its old index or accumulator. The third restarts on the final cycle, which catches a design whose end-of-frame clear wins over the start. A second instance built without dither confirms the plain stride walk.

// File: rtl/perm_pkg.sv
package perm_pkg;

   // mask of n low ones, n < 32
   function automatic logic [31:0] low_ones(input int unsigned n);
      return (32'd1 << n) - 32'd1;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/perm_frame_ctrl.sv
module perm_frame_ctrl #(
   parameter int unsigned KMIN_LOG  = 5,
   parameter int unsigned NUM_SIZES = 3,
   parameter int unsigned Q         = 4,
   parameter int unsigned AW        = 7,
   parameter int unsigned SELW      = 2,
   parameter int unsigned LW        = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [SELW-1:0] size_sel_i,
   output logic            run_o,
   output logic            last_o,
   output logic [AW-1:0]   idx_o,
   output logic [LW-1:0]   layer_o,
   output logic [AW-1:0]   mask_o
);
   localparam logic [LW-1:0]   LAYER_TOP = LW'(Q - 1);
   localparam logic [SELW-1:0] SEL_TOP   = SELW'(NUM_SIZES - 1);

   logic            run_q;
   logic [AW-1:0]   idx_q;
   logic [AW-1:0]   mask_q;
   logic [LW-1:0]   layer_q;
   logic [SELW-1:0] sel_eff;
   logic [31:0]     ones;
   logic [AW-1:0]   mask_new;

   always_comb begin
      sel_eff  = (32'(size_sel_i) >= NUM_SIZES) ? SEL_TOP : size_sel_i;
      ones     = perm_pkg::low_ones(KMIN_LOG + 32'(sel_eff));
      mask_new = ones[AW-1:0];
   end

   assign last_o = run_q && (idx_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         idx_q   <= '0;
         layer_q <= '0;
         mask_q  <= '0;
      end else if (start_i) begin
         run_q   <= 1'b1;
         idx_q   <= '0;
         layer_q <= '0;
         mask_q  <= mask_new;
      end else if (run_q) begin
         run_q   <= !last_o;
         idx_q   <= idx_q + 1'b1;
         layer_q <= (layer_q == LAYER_TOP) ? '0 : layer_q + 1'b1;
      end
   end

   assign run_o   = run_q;
   assign idx_o   = idx_q;
   assign layer_o = layer_q;
   assign mask_o  = mask_q;

   // R2 / R6: a start pulse always lands on index 0, layer 0
   assert_start_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (run_o && idx_o == '0 && layer_o == '0));

   // R5: frame closes after its final index unless restarted
   assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !run_o);

   // R3: separate layer counter stays in step with low index bits
   assert_layer_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (layer_o == idx_o[LW-1:0]));

   // R4: size is frozen for the whole frame
   assert_size_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && !start_i) |=> (mask_o == $past(mask_o)));

endmodule

// File: rtl/perm_accum.sv
module perm_accum #(
   parameter int unsigned AW = 7,
   parameter int unsigned P  = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          step_i,
   input  logic [AW-1:0] mask_i,
   output logic [AW-1:0] acc_o
);
   // P mod 2**AW; the frame mask finishes the reduction mod K
   localparam logic [AW-1:0] P_RED = AW'(P);

   logic [AW-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (step_i)  acc_q <= (acc_q + P_RED) & mask_i;
   end

   assign acc_o = acc_q;

   // R7: the running product never leaves the current frame
   assert_acc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> ((acc_o & ~mask_i) == '0));

endmodule

// File: rtl/perm_dither.sv
module perm_dither #(
   parameter int unsigned AW = 7,
   parameter int unsigned LW = 2,
   parameter int unsigned Q  = 4,
   parameter int unsigned SHIFTS [Q] = '{3, 13, 27, 5}
) (
   input  logic [AW-1:0] acc_i,
   input  logic [LW-1:0] layer_i,
   input  logic [AW-1:0] mask_i,
   output logic [AW-1:0] addr_o
);
   function automatic bit table_is_zero();
      bit z = 1'b1;
      for (int k = 0; k < int'(Q); k++) if (SHIFTS[k] != 0) z = 1'b0;
      return z;
   endfunction

   localparam bit NO_DITHER = table_is_zero();

   if (NO_DITHER) begin : g_plain
      assign addr_o = acc_i & mask_i;
   end else begin : g_dither
      logic [AW-1:0] tab [Q];
      for (genvar g = 0; g < int'(Q); g++) begin : g_entry
         assign tab[g] = AW'(SHIFTS[g]);
      end
      assign addr_o = (acc_i + tab[layer_i]) & mask_i;
   end

endmodule

// File: rtl/perm_addr_gen.sv
module perm_addr_gen #(
   parameter int unsigned P          = 9,
   parameter int unsigned Q          = 4,
   parameter int unsigned SHIFTS [Q] = '{3, 13, 27, 5},
   parameter int unsigned KMIN_LOG   = 5,
   parameter int unsigned NUM_SIZES  = 3,
   localparam int unsigned AW   = KMIN_LOG + NUM_SIZES - 1,
   localparam int unsigned SELW = (NUM_SIZES > 2) ? $clog2(NUM_SIZES) : 1,
   localparam int unsigned LW   = (Q > 2) ? $clog2(Q) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [SELW-1:0] size_sel_i,
   output logic [AW-1:0]   addr_o,
   output logic            valid_o,
   output logic            last_o
);
   logic            run;
   logic            last;
   logic [AW-1:0]   idx;
   logic [LW-1:0]   layer;
   logic [AW-1:0]   mask;
   logic [AW-1:0]   acc;
   logic [AW-1:0]   addr;

   // elaboration-time parameter checks
   initial begin
      if (P % 2 == 0) $error("stride must be odd");
      if (!perm_pkg::is_pow2(Q) || Q < 2) $error("group length must be a power of two >= 2");
      if (Q > (1 << KMIN_LOG)) $error("group length exceeds smallest frame");
      if (AW >= 31) $error("frame width too large");
      for (int a = 0; a < int'(Q); a++)
         for (int b = a + 1; b < int'(Q); b++)
            if (((P * a + SHIFTS[a]) % Q) == ((P * b + SHIFTS[b]) % Q))
               $error("dither table breaks the permutation");
   end

   perm_frame_ctrl #(
      .KMIN_LOG (KMIN_LOG), .NUM_SIZES (NUM_SIZES), .Q (Q),
      .AW (AW), .SELW (SELW), .LW (LW)
   ) i_ctrl (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .size_sel_i (size_sel_i),
      .run_o (run), .last_o (last), .idx_o (idx), .layer_o (layer), .mask_o (mask)
   );

   perm_accum #(.AW (AW), .P (P)) i_accum (
      .clk (clk), .rst_n (rst_n), .clear_i (start_i), .step_i (run),
      .mask_i (mask), .acc_o (acc)
   );

   perm_dither #(.AW (AW), .LW (LW), .Q (Q), .SHIFTS (SHIFTS)) i_dither (
      .acc_i (acc), .layer_i (layer), .mask_i (mask), .addr_o (addr)
   );

   assign addr_o  = addr;
   assign valid_o = run;
   assign last_o  = last;

   // R7: every emitted address lies inside the latched frame
   assert_addr_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ((addr_o & ~mask) == '0));

   // R1 / R5: the final flag only appears on a valid cycle
   assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> (valid_o && idx == mask));

endmodule

// File: tb/test_perm_addr_gen.sv
module test_perm_addr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int NF = 5;
   localparam logic [1:0] FRAME_SEL [NF] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
   localparam int         FRAME_K   [NF] = '{32, 64, 128, 128, 32};
   localparam int         SREF      [4]  = '{3, 13, 27, 5};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [6:0] addr, addr_plain;
   logic       valid, last, valid_plain, last_plain;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit seen [128];
   int dups;

   always #(CLK_PERIOD / 2) clk = ~clk;

   perm_addr_gen i_perm_addr_gen (
      .clk (clk), .rst_n (rst_n), .start_i (start), .size_sel_i (sel),
      .addr_o (addr), .valid_o (valid), .last_o (last)
   );

   perm_addr_gen #(.SHIFTS ('{0, 0, 0, 0})) i_perm_addr_gen_plain (
      .clk (clk), .rst_n (rst_n), .start_i (start), .size_sel_i (sel),
      .addr_o (addr_plain), .valid_o (valid_plain), .last_o (last_plain)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int ref_addr(input int i, input int k);
      return (9 * i + SREF[i % 4]) % k;
   endfunction

   // called at a negedge; leaves start low one negedge later
   task automatic pulse_start(input logic [1:0] s);
      start = 1'b1;
      sel   = s;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic check_index(input int i, input int k);
      chk("R3 valid", int'(valid), 1);
      chk("R3 addr", int'(addr), ref_addr(i, k));
      chk("R5 last", int'(last), int'(i == k - 1));
      chk("R8 plain addr", int'(addr_plain), (9 * i) % k);
      if (seen[addr]) dups++;
      seen[addr] = 1'b1;
   endtask

   // checks indices 0..n-1, leaves sim at negedge showing index n
   task automatic run_span(input int k, input int n);
      for (int j = 0; j < 128; j++) seen[j] = 1'b0;
      dups = 0;
      for (int i = 0; i < n; i++) begin
         check_index(i, k);
         @(negedge clk);
      end
   endtask

   task automatic check_coverage(input int k);
      int miss = 0;
      for (int j = 0; j < k; j++) if (!seen[j]) miss++;
      chk("R7 duplicates", dups, 0);
      chk("R7 missing", miss, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", int'(valid), 0);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R1 valid idle", int'(valid), 0);
         chk("R1 last idle", int'(last), 0);
      end

      // table of frames, one per size code (R2, R3, R4, R5, R7, R8)
      for (int f = 0; f < NF; f++) begin
         pulse_start(FRAME_SEL[f]);
         chk("R2 first addr", int'(addr), SREF[0] % FRAME_K[f]);
         run_span(FRAME_K[f], FRAME_K[f]);
         check_coverage(FRAME_K[f]);
         chk("R5 valid after last", int'(valid), 0);
         chk("R5 last after frame", int'(last), 0);
      end

      // R4: size code changed mid-frame is ignored
      pulse_start(2'd0);
      for (int j = 0; j < 128; j++) seen[j] = 1'b0;
      dups = 0;
      for (int i = 0; i < 32; i++) begin
         if (i == 5) sel = 2'd2;
         check_index(i, 32);
         @(negedge clk);
      end
      check_coverage(32);
      chk("R4 frame length kept", int'(valid), 0);

      // R6: restart mid-frame with a new size
      pulse_start(2'd2);
      run_span(128, 10);
      check_index(10, 128);
      pulse_start(2'd1);
      run_span(64, 64);
      check_coverage(64);
      chk("R6 restarted frame ends", int'(valid), 0);

      // R6: restart on the final cycle of a frame
      pulse_start(2'd0);
      run_span(32, 31);
      check_index(31, 32);
      pulse_start(2'd0);
      chk("R6 restart at last valid", int'(valid), 1);
      run_span(32, 32);
      check_coverage(32);
      chk("R6 end after restart", int'(valid), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule